// File: doc/BRIEF.md
# Watchdog Timer with Run-Time Expiry Action

This block is a watchdog peripheral on a simple 32-bit register bus. Software loads a tick count into the timer register. The count then falls by one on every clock cycle. Writing the timer register again restarts the count, and this write is the only keepalive.

When the count reaches zero, the block carries out the action held in the control register. The four choices are: do nothing, raise a maskable interrupt, raise a non-maskable interrupt, or request a full chip reset. The two interrupt choices drive level outputs. The reset choice drives a single pulse of fixed length.

A new timer value needs a few cycles to reach the counter, and while it is in transit an expired count is not acted on. A sticky flag records that the watchdog requested a chip reset. The flag has its own power-on reset input, so it keeps its value through the ordinary reset that the chip reset generator asserts. Software can read it back after reboot to learn why the chip restarted.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset (`por_ni` and `rst_ni` both low), the action field reads 0, the reset-cause bit reads 0 and the counter holds 0xFFFFFFFF. A read accepted on a clock edge returns its data with `rvalid_o` high during the following cycle. The control register is at byte offset 0x0 and the timer register at 0x4.
- R2: A write to offset 0x4 places the written value in the counter SYNC_STAGES cycles after the write edge. From then on the counter drops by one per cycle. A timer read returns the live count.
- R3: The counter stops at zero and never wraps.
- R4: While a timer write is still in transit to the counter, a zero count triggers no action.
- R5: Action code 1 (control bits [1:0]) drives `irq_o` high whenever the count is zero and no load is in transit, and keeps `nmi_o` low.
- R6: Action code 2 drives `nmi_o` high under the same condition, and keeps `irq_o` low.
- R7: Action code 0 keeps `irq_o`, `nmi_o` and `rst_req_o` low, even when the count is zero.
- R8: `irq_o` and `nmi_o` are levels that stay high until the timer is rewritten or the action is changed. Either change clears them in the cycle after the write edge.
- R9: Action code 3 makes `rst_req_o` high for exactly RST_PULSE cycles, starting one cycle after expiry is seen. It fires once for each expiry.
- R10: Control bit 31 reads 1 once a chip-reset request has been issued. It keeps that value through `rst_ni` and is cleared only by `por_ni`.
- R11: Writes to control bits [31:2] and writes to offsets other than 0x0 and 0x4 have no effect on either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Watchdog clock |
| rst_ni | input | 1 | Active-low asynchronous system reset, also asserted by the chip reset |
| por_ni | input | 1 | Active-low asynchronous power-on reset for the cause flag |
| req_i | input | 1 | Bus access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Level interrupt on expiry |
| nmi_o | output | 1 | Level non-maskable interrupt on expiry |
| rst_req_o | output | 1 | Chip reset request pulse |

## Verification
The hardest situation to reach from the ports is a count that is already zero while a fresh load is still in transit. Here the outputs must drop and then come back once the load lands. The stimulus first lets the counter expire under the interrupt action, then writes a zero timer value. It samples `irq_o` on each cycle of the transfer and on the cycle after it.

The second hard situation is the cause flag surviving a system reset. The bench issues a reset-action expiry, pulses only `rst_ni`, and reads the control register back. It then pulses `por_ni` and reads the register again.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_IRQ  = 2'd1,
    ACT_NMI  = 2'd2,
    ACT_RST  = 2'd3
  } wdog_act_e;

  localparam int unsigned DATA_W    = 32;
  localparam int unsigned CTRL_OFS  = 0;
  localparam int unsigned TIMER_OFS = 4;
  localparam int unsigned CAUSE_BIT = DATA_W - 1;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              cause_i,
  output wdog_act_e         act_o,
  output logic              tmr_wr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic sel_ctrl, sel_tmr, rd;
  logic [DATA_W-1:0] rmux;

  assign sel_ctrl = (addr_i == ADDR_W'(CTRL_OFS));
  assign sel_tmr  = (addr_i == ADDR_W'(TIMER_OFS));
  assign rd       = req_i & ~we_i;
  assign tmr_wr_o = req_i & we_i & sel_tmr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_o <= ACT_NONE;
    else if (req_i && we_i && sel_ctrl) act_o <= wdog_act_e'(wdata_i[1:0]);
  end

  always_comb begin
    rmux = '0;
    if (sel_ctrl) begin
      rmux[1:0]       = act_o;
      rmux[CAUSE_BIT] = cause_i;
    end else if (sel_tmr) begin
      rmux = cnt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rmux;
    end
  end
endmodule

// File: rtl/wdog_load_sync.sv
module wdog_load_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] val_i,
  output logic         load_o,
  output logic [W-1:0] val_o,
  output logic         pending_o
);
  logic [STAGES-1:0] sync_q;
  logic [W-1:0]      hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else if (wr_i) hold_q <= val_i;
  end

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else sync_q <= {sync_q[STAGES-2:0], wr_i};
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else sync_q <= wr_i;
      end
    end
  endgenerate

  assign load_o    = sync_q[STAGES-1];
  assign val_o     = hold_q;
  assign pending_o = |sync_q;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '1;
    else if (load_i) cnt_o <= val_i;
    else if (cnt_o != '0) cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/wdog_action.sv
module wdog_action
  import wdog_pkg::*;
#(
  parameter int unsigned RST_PULSE = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      por_ni,
  input  wdog_act_e act_i,
  input  logic      expired_i,
  output logic      irq_o,
  output logic      nmi_o,
  output logic      rst_req_o,
  output logic      cause_o
);
  localparam int unsigned PCW = $clog2(RST_PULSE + 1);

  logic           fired_q, fire, rst_arm;
  logic [PCW-1:0] pulse_q;

  assign irq_o   = expired_i && (act_i == ACT_IRQ);
  assign nmi_o   = expired_i && (act_i == ACT_NMI);
  assign rst_arm = expired_i && (act_i == ACT_RST);
  assign fire    = rst_arm && !fired_q;   // one request per expiry

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fired_q <= 1'b0;
      pulse_q <= '0;
    end else begin
      fired_q <= rst_arm;
      if (fire) pulse_q <= PCW'(RST_PULSE);
      else if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
    end
  end

  assign rst_req_o = (pulse_q != '0);

  // cause flag lives in the power-on domain
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) cause_o <= 1'b0;
    else if (fire) cause_o <= 1'b1;
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 3,
  parameter int unsigned RST_PULSE   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o,
  output logic              irq_o,
  output logic              nmi_o,
  output logic              rst_req_o
);
  wdog_act_e         act;
  logic              tmr_wr, load, pending, cause, expired;
  logic [DATA_W-1:0] load_val, cnt;

  wdog_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cnt_i   (cnt),
    .cause_i (cause),
    .act_o   (act),
    .tmr_wr_o(tmr_wr),
    .rdata_o (rdata_o),
    .rvalid_o(rvalid_o)
  );

  wdog_load_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (tmr_wr),
    .val_i    (wdata_i),
    .load_o   (load),
    .val_o    (load_val),
    .pending_o(pending)
  );

  wdog_counter #(.W(DATA_W)) i_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .val_i (load_val),
    .cnt_o (cnt)
  );

  assign expired = (cnt == '0) && !pending;

  wdog_action #(.RST_PULSE(RST_PULSE)) i_act (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .por_ni   (por_ni),
    .act_i    (act),
    .expired_i(expired),
    .irq_o    (irq_o),
    .nmi_o    (nmi_o),
    .rst_req_o(rst_req_o),
    .cause_o  (cause)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        por_ni,
  input logic [1:0]  act_i,
  input logic [31:0] cnt_i,
  input logic        pending_i,
  input logic        cause_i,
  input logic        irq_o,
  input logic        nmi_o,
  input logic        rst_req_o
);
  p_dec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != 32'd0 && !pending_i) |=> (cnt_i == $past(cnt_i) - 32'd1));

  p_hold_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == 32'd0 && !pending_i) |=> (cnt_i == 32'd0));

  p_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_i |-> (!irq_o && !nmi_o));

  p_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (act_i == 2'd1 && cnt_i == 32'd0 && !nmi_o));

  p_nmi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> (act_i == 2'd2 && cnt_i == 32'd0 && !irq_o));

  p_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == 2'd0) |-> (!irq_o && !nmi_o));

  p_pulse_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> ($past(act_i) == 2'd3));

  p_cause_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> cause_i);

  p_cause_sticky_r10: assert property (@(posedge clk_i) disable iff (!por_ni)
    cause_i |=> cause_i);
endmodule

bind wdog_timer wdog_timer_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .por_ni   (por_ni),
  .act_i    (act),
  .cnt_i    (cnt),
  .pending_i(pending),
  .cause_i  (cause),
  .irq_o    (irq_o),
  .nmi_o    (nmi_o),
  .rst_req_o(rst_req_o)
);

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  localparam int S = 3;
  localparam int P = 4;
  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_TMR  = 4'h4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0, por_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o, irq_o, nmi_o, rst_req_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk_i = ~clk_i;

  wdog_timer #(.ADDR_W(4), .SYNC_STAGES(S), .RST_PULSE(P)) i_wdog_timer (
    .clk_i, .rst_ni, .por_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .rdata_o, .rvalid_o, .irq_o, .nmi_o, .rst_req_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // callers sit at a negedge; each access occupies one posedge
  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic outs(input string t, input logic i, input logic n, input logic r);
    check(t, {29'd0, i, n, r}, {29'd0, irq_o, nmi_o, rst_req_o} == {i, n, r} ? {29'd0, i, n, r} : {29'd0, irq_o, nmi_o, rst_req_o});
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rvalid_o) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R1: unexpected read data %h, expected none", rdata_o);
      end else begin
        check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1; por_ni = 1'b1;
    // R1 reset state
    bus_read(A_TMR, 32'hFFFF_FFFF, "R1 timer reset");
    bus_read(A_CTRL, 32'h0, "R1 ctrl reset");
    check("R1 outputs idle", {29'd0, irq_o, nmi_o, rst_req_o}, 32'd0);

    // R11 read-only bits and unmapped offset
    bus_write(A_CTRL, 32'hFFFF_FFFD);
    bus_read(A_CTRL, 32'h1, "R11 upper ctrl bits ignored");
    bus_write(4'h8, 32'h2);
    bus_read(A_CTRL, 32'h1, "R11 unmapped write ignored");

    // R2 load latency and decrement
    bus_write(A_TMR, 32'd20);
    repeat (S) @(negedge clk_i);
    bus_read(A_TMR, 32'd20, "R2 loaded value");
    repeat (3) @(negedge clk_i);
    bus_read(A_TMR, 32'd16, "R2 decrement");
    repeat (14) @(negedge clk_i);
    check("R5 irq before expiry", {31'd0, irq_o}, 32'd0);
    @(negedge clk_i);
    check("R5 irq at expiry", {31'd0, irq_o}, 32'd1);
    check("R5 nmi stays low", {31'd0, nmi_o}, 32'd0);
    repeat (5) @(negedge clk_i);
    bus_read(A_TMR, 32'd0, "R3 no wrap");
    check("R8 irq level held", {31'd0, irq_o}, 32'd1);

    // R4 expiry gated while load in transit
    bus_write(A_TMR, 32'd0);
    check("R4 gated first cycle", {31'd0, irq_o}, 32'd0);
    repeat (S - 1) @(negedge clk_i);
    check("R4 gated last cycle", {31'd0, irq_o}, 32'd0);
    @(negedge clk_i);
    check("R4 irq after landing", {31'd0, irq_o}, 32'd1);

    // R8 keepalive clears level
    bus_write(A_TMR, 32'd100);
    check("R8 reload clears irq", {31'd0, irq_o}, 32'd0);
    repeat (S + 2) @(negedge clk_i);
    check("R8 irq stays low", {31'd0, irq_o}, 32'd0);

    bus_write(A_TMR, 32'd2);
    repeat (S + 4) @(negedge clk_i);
    check("R5 re-expiry", {31'd0, irq_o}, 32'd1);
    bus_write(A_CTRL, 32'h0);
    check("R8 action 0 clears irq", {31'd0, irq_o}, 32'd0);
    repeat (3) @(negedge clk_i);
    check("R7 disabled quiet", {29'd0, irq_o, nmi_o, rst_req_o}, 32'd0);
    bus_write(A_CTRL, 32'h2);
    check("R6 nmi asserted", {31'd0, nmi_o}, 32'd1);
    check("R6 irq low", {31'd0, irq_o}, 32'd0);

    // R9 reset pulse
    bus_write(A_CTRL, 32'h3);
    check("R9 no request yet", {29'd0, irq_o, nmi_o, rst_req_o}, 32'd0);
    for (int k = 0; k < P; k++) begin
      @(negedge clk_i);
      check("R9 pulse high", {31'd0, rst_req_o}, 32'd1);
    end
    @(negedge clk_i);
    check("R9 pulse ends", {31'd0, rst_req_o}, 32'd0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i);
      check("R9 single pulse", {31'd0, rst_req_o}, 32'd0);
    end
    bus_read(A_CTRL, 32'h8000_0003, "R10 cause set");

    // R10 survives system reset
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    bus_read(A_CTRL, 32'h8000_0000, "R10 cause kept over rst_ni");
    bus_write(A_CTRL, 32'h0);
    bus_read(A_CTRL, 32'h8000_0000, "R11 cause not writable");
    por_ni = 1'b0; rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    por_ni = 1'b1; rst_ni = 1'b1;
    bus_read(A_CTRL, 32'h0, "R10 cleared by por");

    // R7 expiry with action 0
    bus_write(A_TMR, 32'd1);
    repeat (S + 5) @(negedge clk_i);
    check("R7 no action on expiry", {29'd0, irq_o, nmi_o, rst_req_o}, 32'd0);
    bus_read(A_TMR, 32'd0, "R3 stays zero");

    repeat (3) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R1: %0d reads unanswered, expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule